// File: doc/BRIEF.md
# Serial Configuration Stream Frame Checker

This block takes a configuration bitstream one bit per clock, qualified by a valid strobe, and checks its framing. It skips the leading run of ones, finds the header pattern, keeps the 24-bit length count, and then cuts the rest of the stream into a fixed number of frames. Each frame has a fixed data length. A trailer ends every frame. Depending on a mode input, the trailer is either a fixed constant or a slice of a CRC-16 that runs across all frame data. When that slice belongs to the last frame, it is widened to eleven bits.

Each frame that passes its check is presented with a one-cycle valid pulse. A bad fill, a bad start bit, a bad trailer or a bad closing pattern stops parsing and pulls the active-low error output low. The block then ignores its input until a program pulse or a reset. After the last frame, the closing pattern must arrive before the done output rises. Once done is high, the trailing ones are ignored.

Top module: `cfg_frame_checker`

## Requirements
- R1: After reset or a program pulse, init_n is 1, done is 0 and frame_vld is 0, and the block is searching for a header.
- R2: Cycles with bit_vld low carry no bit. Leading ones are skipped. The header is the four bits 0,0,1,0 in arrival order.
- R3: The 24 bits after the header are the length count, first bit as the MSB. They appear on len_count.
- R4: The four bits after the length count must all be 1. Any 0 among them is an error.
- R5: Every frame opens with one start bit that must be 0. A 1 is an error.
- R6: With crc_mode low, every frame's data is followed by four check bits that must read 0,1,1,0 in arrival order. Anything else is an error.
- R7: With crc_mode high, a CRC-16 with polynomial 0x8005 runs MSB-first. On each data bit: feedback = bit XOR crc[15], crc shifts left, and if feedback is 1 the polynomial is XORed in. Only frame data bits update it. It is loaded with CRC_SEED when the header is found. A frame other than the last carries crc[3:0] as its check, sent bit 3 first.
- R8: With crc_mode high, the last frame carries eleven check bits equal to crc[10:0], sent bit 10 first.
- R9: A frame whose check passes raises frame_vld for exactly one cycle. frame_data then holds that frame's data with the first data bit in the MSB. frame_data changes at no other time.
- R10: On any error, init_n goes low and stays low. No frame_vld and no done follow, and every further bit is ignored until prog_n is low.
- R11: After the last frame, the eight bits 0,1,1,1,1,1,1,1 must arrive; then done goes high and later bits are ignored. A wrong closing pattern is an error.
- R12: prog_n low returns the block to header search. It wins over a valid bit presented in the same cycle, and that bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Synchronous active-low program pulse, restarts the parse |
| crc_mode | input | 1 | 1 selects CRC trailers, 0 selects the constant trailer |
| bit_vld | input | 1 | Qualifies bit_in |
| bit_in | input | 1 | Serial stream bit |
| init_n | output | 1 | Active-low error indication |
| done | output | 1 | Whole stream checked and closed |
| frame_vld | output | 1 | One-cycle pulse per passing frame |
| frame_data | output | FRAME_BITS | Data of the last passing frame |
| len_count | output | 24 | Captured length count |

## Verification
Two things can happen in one cycle: a program pulse and a valid stream bit. The bench raises both with a 0 on the bit line, then sends 0,1,0 and a body made only of ones and constant trailers. If the dropped bit had been taken, those bits would complete a header and the body would parse through to done. Under the requirement, the design must stay in header search with done low and no frames. Sweeps over both modes, four data patterns with and without idle gaps, and corruption of every frame's trailer, the fill, a start bit and the closing pattern check the frame counts, the data, the length and the flags against values the bench computes itself.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

    typedef enum logic [3:0] {
        PH_HUNT,
        PH_LEN,
        PH_FILL,
        PH_START,
        PH_DATA,
        PH_CHECK,
        PH_POST,
        PH_DONE,
        PH_ERR
    } phase_e;

    localparam logic [3:0] HDR_PAT     = 4'b0010;
    localparam logic [3:0] FILL_PAT    = 4'b1111;
    localparam logic [3:0] TRAILER_PAT = 4'b0110;
    localparam logic [7:0] CLOSE_PAT   = 8'b0111_1111;
    localparam int         SHORT_CHK   = 4;
    localparam int         LONG_CHK    = 11;

endpackage

// File: rtl/cfgchk_crc_step.sv
module cfgchk_crc_step #(
    parameter logic [15:0] POLY = 16'h8005
) (
    input  logic [15:0] crc_i,
    input  logic        bit_i,
    output logic [15:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = bit_i ^ crc_i[15];
        crc_o = {crc_i[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
    end
endmodule

// File: rtl/cfgchk_pattern_det.sv
module cfgchk_pattern_det #(
    parameter int           W   = 4,
    parameter logic [W-1:0] PAT = '0
) (
    input  logic [W-1:0] win,
    output logic         hit
);
    assign hit = (win == PAT);
endmodule

// File: rtl/cfgchk_trailer_cmp.sv
module cfgchk_trailer_cmp
    import cfgchk_pkg::*;
(
    input  logic        crc_mode,
    input  logic        last,
    input  logic [10:0] chk,
    input  logic [10:0] crc,
    output logic        pass
);
    always_comb begin
        if (!crc_mode) begin
            pass = (chk[3:0] == TRAILER_PAT);
        end else if (last) begin
            pass = (chk == crc);
        end else begin
            pass = (chk[3:0] == crc[3:0]);
        end
    end
endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
    import cfgchk_pkg::*;
#(
    parameter int          FRAME_BITS = 12,
    parameter int          NUM_FRAMES = 3,
    parameter int          LEN_BITS   = 24,
    parameter logic [15:0] CRC_SEED   = 16'hFFFF,
    parameter logic [15:0] CRC_POLY   = 16'h8005
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prog_n,
    input  logic                  crc_mode,
    input  logic                  bit_vld,
    input  logic                  bit_in,
    output logic                  init_n,
    output logic                  done,
    output logic                  frame_vld,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic [LEN_BITS-1:0]   len_count
);
    localparam int CNT_MAX0 = (LEN_BITS > FRAME_BITS) ? LEN_BITS : FRAME_BITS;
    localparam int CNT_MAX  = (CNT_MAX0 > LONG_CHK) ? CNT_MAX0 : LONG_CHK;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int FRM_W    = $clog2(NUM_FRAMES + 1);

    typedef struct packed {
        phase_e                phase;
        logic [3:0]            hwin;
        logic [CNT_W-1:0]      cnt;
        logic [FRM_W-1:0]      left;
        logic [LEN_BITS-1:0]   len;
        logic [15:0]           crc;
        logic [FRAME_BITS-1:0] dat;
        logic [LONG_CHK-2:0]   chk;
        logic [6:0]            post;
        logic [FRAME_BITS-1:0] fout;
        logic                  fvld;
    } state_t;

    state_t s_d, s_q;

    logic [15:0]         crc_nx;
    logic                hdr_hit;
    logic                close_hit;
    logic                chk_pass;
    logic                last_frm;
    logic [CNT_W-1:0]    chk_end;

    assign last_frm = (s_q.left == FRM_W'(1));
    assign chk_end  = (crc_mode && last_frm) ? CNT_W'(LONG_CHK - 1) : CNT_W'(SHORT_CHK - 1);

    cfgchk_crc_step #(.POLY(CRC_POLY)) u_crc (
        .crc_i (s_q.crc),
        .bit_i (bit_in),
        .crc_o (crc_nx)
    );

    cfgchk_pattern_det #(.W(4), .PAT(HDR_PAT)) u_hdr (
        .win ({s_q.hwin[2:0], bit_in}),
        .hit (hdr_hit)
    );

    cfgchk_pattern_det #(.W(8), .PAT(CLOSE_PAT)) u_close (
        .win ({s_q.post, bit_in}),
        .hit (close_hit)
    );

    cfgchk_trailer_cmp u_trl (
        .crc_mode (crc_mode),
        .last     (last_frm),
        .chk      ({s_q.chk, bit_in}),
        .crc      (s_q.crc[10:0]),
        .pass     (chk_pass)
    );

    always_comb begin
        s_d      = s_q;
        s_d.fvld = 1'b0;
        if (!prog_n) begin
            s_d.phase = PH_HUNT;
            s_d.hwin  = FILL_PAT;
            s_d.cnt   = '0;
        end else if (bit_vld) begin
            unique case (s_q.phase)
                PH_HUNT: begin
                    s_d.hwin = {s_q.hwin[2:0], bit_in};
                    if (hdr_hit) begin
                        s_d.phase = PH_LEN;
                        s_d.cnt   = '0;
                        s_d.crc   = CRC_SEED;
                        s_d.left  = FRM_W'(NUM_FRAMES);
                    end
                end
                PH_LEN: begin
                    s_d.len = {s_q.len[LEN_BITS-2:0], bit_in};
                    if (s_q.cnt == CNT_W'(LEN_BITS - 1)) begin
                        s_d.phase = PH_FILL;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_FILL: begin
                    if (!bit_in) begin
                        s_d.phase = PH_ERR;
                    end else if (s_q.cnt == CNT_W'(3)) begin
                        s_d.phase = PH_START;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_START: begin
                    s_d.phase = bit_in ? PH_ERR : PH_DATA;
                    s_d.cnt   = '0;
                end
                PH_DATA: begin
                    s_d.dat = {s_q.dat[FRAME_BITS-2:0], bit_in};
                    s_d.crc = crc_nx;
                    if (s_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                        s_d.phase = PH_CHECK;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_CHECK: begin
                    s_d.chk = {s_q.chk[LONG_CHK-3:0], bit_in};
                    if (s_q.cnt == chk_end) begin
                        s_d.cnt = '0;
                        if (chk_pass) begin
                            s_d.fvld  = 1'b1;
                            s_d.fout  = s_q.dat;
                            s_d.left  = s_q.left - 1'b1;
                            s_d.phase = last_frm ? PH_POST : PH_START;
                        end else begin
                            s_d.phase = PH_ERR;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_POST: begin
                    s_d.post = {s_q.post[5:0], bit_in};
                    if (s_q.cnt == CNT_W'(7)) begin
                        s_d.phase = close_hit ? PH_DONE : PH_ERR;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_HUNT;
            s_q.hwin  <= FILL_PAT;
            s_q.crc   <= CRC_SEED;
            s_q.left  <= FRM_W'(NUM_FRAMES);
        end else begin
            s_q <= s_d;
        end
    end

    assign init_n     = (s_q.phase != PH_ERR);
    assign done       = (s_q.phase == PH_DONE);
    assign frame_vld  = s_q.fvld;
    assign frame_data = s_q.fout;
    assign len_count  = s_q.len;
endmodule

// File: rtl/cfgchk_sva.sv
module cfgchk_sva #(
    parameter int FRAME_BITS = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  prog_n,
    input logic                  init_n,
    input logic                  done,
    input logic                  frame_vld,
    input logic [FRAME_BITS-1:0] frame_data
);
    AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> (init_n && !done && !frame_vld));                 // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_n && prog_n) |=> !init_n);                             // R10
    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> !frame_vld);                                      // R10
    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);                                    // R9
    AST_DATA_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_data) |-> frame_vld);                          // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && prog_n) |=> done);                                   // R11
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !frame_vld);                                         // R11
endmodule

bind cfg_frame_checker cfgchk_sva #(.FRAME_BITS(FRAME_BITS)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_n     (prog_n),
    .init_n     (init_n),
    .done       (done),
    .frame_vld  (frame_vld),
    .frame_data (frame_data)
);

// File: tb/sim_cfg_frame_checker.sv
module sim_cfg_frame_checker;
    localparam int FB = 12;
    localparam int NF = 3;
    localparam logic [15:0] SEED = 16'hFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_n = 1'b1;
    logic crc_mode = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic init_n, done, frame_vld;
    logic [FB-1:0] frame_data;
    logic [23:0] len_count;

    int checks = 0;
    int bad = 0;
    int nrx = 0;
    int gap = 0;
    logic [FB-1:0] rx [0:7];

    always #10 clk = ~clk;

    cfg_frame_checker #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .LEN_BITS(24),
                        .CRC_SEED(SEED), .CRC_POLY(16'h8005)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .crc_mode(crc_mode),
        .bit_vld(bit_vld), .bit_in(bit_in), .init_n(init_n), .done(done),
        .frame_vld(frame_vld), .frame_data(frame_data), .len_count(len_count)
    );

    always @(negedge clk) begin
        if (frame_vld) begin
            if (nrx < 8) rx[nrx] = frame_data;
            nrx++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = b ^ c[15];
        return {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
    endfunction

    function automatic logic [FB-1:0] word_of(input int p, input int f, input bit ones);
        return ones ? '1 : FB'((p * 1443 + f * 455 + 43) & 12'hFFF);
    endfunction

    task automatic send_bit(input logic b);
        bit_vld = 1'b1;
        bit_in  = b;
        @(posedge clk); #1;
        if (gap != 0) begin
            bit_vld = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    task automatic pulse_prog();
        prog_n = 1'b0;
        @(posedge clk); #1;
        prog_n = 1'b1;
        nrx = 0;
    endtask

    // kind: 0 clean, 1 flip first check bit of frame cf, 2 bad fill, 3 bad start bit of cf, 4 bad close
    task automatic send_body(input int mode, input int p, input int kind, input int cf, input bit ones);
        logic [15:0] c;
        logic [23:0] lv;
        logic [FB-1:0] w;
        logic [10:0] cb;
        int nchk;
        c  = SEED;
        lv = ones ? 24'hFFFFFF : 24'h0A5C30 + 24'(p);
        for (int i = 23; i >= 0; i--) send_bit(lv[i]);
        for (int i = 0; i < 4; i++) send_bit(!(kind == 2 && i == 1));
        for (int f = 0; f < NF; f++) begin
            send_bit(kind == 3 && f == cf);
            w = word_of(p, f, ones);
            for (int i = FB - 1; i >= 0; i--) begin
                send_bit(w[i]);
                c = crc_step(c, w[i]);
            end
            if (mode != 0 && f == NF - 1) begin
                nchk = 11; cb = c[10:0];
            end else if (mode != 0) begin
                nchk = 4; cb = {7'd0, c[3:0]};
            end else begin
                nchk = 4; cb = 11'b0110;
            end
            for (int i = nchk - 1; i >= 0; i--)
                send_bit(cb[i] ^ (kind == 1 && f == cf && i == nchk - 1));
        end
        for (int i = 7; i >= 0; i--) send_bit((kind == 4 && i == 0) ? 1'b0 : 8'h7F >> i);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        bit_vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic run_stream(input int mode, input int p, input int kind, input int cf, input bit doprog);
        int nexp;
        crc_mode = mode[0];
        gap = p % 2;
        if (doprog) pulse_prog();
        for (int i = 0; i < 8 + p; i++) send_bit(1'b1);
        send_bit(0); send_bit(0); send_bit(1); send_bit(0);
        send_body(mode, p, kind, cf, 1'b0);
        gap = 0;
        if (!doprog) begin
            chk(nrx == 0, "R10 frames after error", nrx, 0);
            chk(init_n == 1'b0, "R10 init_n held", init_n, 0);
            chk(done == 1'b0, "R10 done held", done, 0);
            return;
        end
        nexp = (kind == 0 || kind == 4) ? NF : (kind == 2) ? 0 : cf;
        chk(nrx == nexp, (kind == 1) ? ((mode != 0) ? ((cf == NF - 1) ? "R8 frame count" : "R7 frame count")
                                                   : "R6 frame count")
                         : (kind == 3) ? "R5 frame count" : (kind == 2) ? "R4 frame count" : "R9 frame count",
            nrx, nexp);
        for (int f = 0; f < nexp && f < nrx; f++)
            chk(rx[f] == word_of(p, f, 1'b0), "R9 frame data", rx[f], word_of(p, f, 1'b0));
        chk(len_count == 24'h0A5C30 + 24'(p), "R3 length count", len_count, 24'h0A5C30 + 24'(p));
        chk(done == (kind == 0), (kind == 4) ? "R11 bad close" : "R11 done", done, kind == 0);
        chk(init_n == (kind == 0), (kind == 0) ? "R2 clean init_n" : "R10 init_n low", init_n, kind == 0);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk(init_n == 1'b1 && done == 1'b0 && frame_vld == 1'b0, "R1 reset state",
            {init_n, done, frame_vld}, 3'b100);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 R6 R7 R8 R9 clean sweeps, odd patterns with idle gaps
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 4; p++)
                run_stream(m, p, 0, 0, 1'b1);

        // R6 R7 R8 trailer corruption in every frame
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < NF; f++)
                run_stream(m, 2, 1, f, 1'b1);

        // R4 R5 R11 framing faults
        for (int m = 0; m < 2; m++) begin
            run_stream(m, 1, 2, 0, 1'b1);
            run_stream(m, 0, 3, 1, 1'b1);
            run_stream(m, 3, 4, 0, 1'b1);
        end

        // R10 error holds without program
        run_stream(0, 0, 1, 0, 1'b1);
        run_stream(0, 0, 0, 0, 1'b0);

        // R12 program pulse and valid bit in the same cycle
        crc_mode = 1'b0;
        gap = 0;
        prog_n = 1'b0; bit_vld = 1'b1; bit_in = 1'b0;
        @(posedge clk); #1;
        prog_n = 1'b1;
        nrx = 0;
        chk(init_n == 1'b1 && done == 1'b0, "R12 cleared", {init_n, done}, 2'b10);
        send_bit(0); send_bit(1); send_bit(0);
        send_body(0, 0, 0, 0, 1'b1);
        chk(done == 1'b0, "R12 bit dropped, done", done, 0);
        chk(nrx == 0, "R12 bit dropped, frames", nrx, 0);
        chk(init_n == 1'b1, "R12 still searching", init_n, 1);

        // R12 recovery after program
        run_stream(1, 1, 0, 0, 1'b1);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule